// File: doc/BRIEF.md
# Two-Level Local Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using that branch's own recent outcomes. A tagged history cache, selected by the low bits of the branch address, keeps one short shift register of past outcomes per branch. That history is XORed with the low address bits, and the result picks one 2-bit saturating counter from a single table that every branch shares. The counter's upper bit is the guess.

The fetch side presents a branch address on the lookup port and receives a registered hit flag and a taken/not-taken guess on the next clock. The execute side reports each resolved branch on the resolve port, with its address and real outcome. The block then moves the selected counter one step toward that outcome and shifts the outcome into the branch's history. A branch that is not yet in the cache gets an entry on its first resolve. The caller drives only the address bits the block uses: the entry index bits followed by the partial tag bits.

Top module: `bp_local_top`

## Requirements
- R1: After synchronous active-low reset, every history entry is empty, every shared counter holds weakly taken (binary 10), and pr_valid, pr_hit and pr_taken are 0.
- R2: A lookup presented with lk_valid=1 at one rising edge gives pr_valid=1 after that edge, with pr_hit and pr_taken for that lookup. In a cycle after an edge with lk_valid=0, all three outputs are 0.
- R3: A lookup whose entry is empty, or whose stored tag differs, gives pr_hit=0 and pr_taken=0.
- R4: A lookup that hits gives pr_hit=1 and pr_taken equal to bit 1 of the shared counter at index (stored history XOR lk_pc[HIST_W-1:0]).
- R5: Counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A taken resolve adds one and stops at 11. A not-taken resolve subtracts one and stops at 00.
- R6: A resolve that hits shifts the history left by one bit. The outcome (1 = taken) enters at bit 0 and the top bit is lost.
- R7: A resolve that misses stores the new tag and uses an all-zero history. It updates the counter at index lk-style (0 XOR upd_pc[HIST_W-1:0]) and leaves the history equal to the outcome in bit 0.
- R8: The entry index is pc[IDX_W-1:0] and the tag is pc[IDX_W+TAG_W-1:IDX_W]. With default sizes this is bits 9:0 and bits 17:10. A resolve to an index that holds another tag replaces that entry, so the earlier branch then misses.
- R9: When a lookup and a resolve happen on the same edge, the lookup result reflects the history and counter from before that resolve.
- R10: Branches whose history-XOR-address values are equal use the same counter, so a resolve of one moves the guess of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | IDX_W+TAG_W (18) | Branch address bits for the lookup: index, then tag |
| upd_valid | input | 1 | Resolved branch reported this cycle |
| upd_pc | input | IDX_W+TAG_W (18) | Branch address bits of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| pr_valid | output | 1 | Registered: a lookup result is present |
| pr_hit | output | 1 | Registered: the history entry matched the tag |
| pr_taken | output | 1 | Registered: guess, 1 = taken |

## Verification
The bench targets both ends of the counter range. It drives a branch taken far past strong taken and then not-taken far past strong not-taken. A counter that wrapped instead of stopping would suddenly flip its guess. It also presents a lookup and a resolve of the same branch on one edge. A design that forwarded the update would return the post-update guess there. Two branches with different tags but the same index are made to evict each other. A design that ignored the tag, or kept the old history on allocation, would report false hits or predictions driven by stale history. A directed pair of branches is arranged to meet on one counter, which exposes any index that drops the XOR with the address. Random traffic over a small pool of conflicting addresses then checks every guess against a model of the requirements.

// File: rtl/bp_pkg.sv
// Shared types and helpers for the local branch predictor.
// Assumes a 2-bit counter where the upper bit is the direction guess.
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_t;

    // Saturating step of a counter toward the resolved outcome.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_t'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bp_hist_cache.sv
// Tagged history cache: one valid bit, partial tag and history per entry.
// Read ports are combinational. The single write port fills or refreshes an
// entry on the next edge. Assumes ENTRIES is a power of two. Only the valid
// bits are reset; tag and history contents are ignored while invalid.
module bp_hist_cache #(
    parameter int ENTRIES = 1024,
    parameter int TAG_W   = 8,
    parameter int HIST_W  = 6,
    parameter int NRD     = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NRD-1:0][IDX_W-1:0]     rd_idx,
    input  logic [NRD-1:0][TAG_W-1:0]     rd_tag,
    output logic [NRD-1:0]                rd_hit,
    output logic [NRD-1:0][HIST_W-1:0]    rd_hist,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [HIST_W-1:0]             wr_hist
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [HIST_W-1:0]  hist_q [ENTRIES];

    // Read ports: tag compare and history fetch, one copy per port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_hit[g]  = valid_q[rd_idx[g]] && (tag_q[rd_idx[g]] == rd_tag[g]);
        assign rd_hist[g] = hist_q[rd_idx[g]];
    end

    // Valid bits: cleared by reset, set by any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and history storage: written on every resolve.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            hist_q[wr_idx] <= wr_hist;
        end
    end

endmodule

// File: rtl/bp_hist_shift.sv
// History update: picks the base history (stored on a hit, zero on a miss)
// and shifts the resolved outcome in at bit 0. Pure combinational logic.
module bp_hist_shift #(
    parameter int HIST_W = 6
) (
    input  logic              hit,
    input  logic [HIST_W-1:0] hist_rd,
    input  logic              taken,
    output logic [HIST_W-1:0] hist_base,
    output logic [HIST_W-1:0] hist_new
);

    // Base history: allocation starts from an empty history.
    always_comb begin
        hist_base = hit ? hist_rd : '0;
    end

    // Shift left, newest outcome at the bottom, oldest bit falls off.
    always_comb begin
        hist_new = (hist_base << 1) | {{(HIST_W-1){1'b0}}, taken};
    end

endmodule

// File: rtl/bp_ctr_table.sv
// Shared table of 2-bit saturating counters, 2**HIST_W deep.
// One combinational guess port and one update port. A guess read on the
// same edge as an update sees the value from before that update.
module bp_ctr_table #(
    parameter int HIST_W = 6,
    localparam int DEPTH = 1 << HIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] pred_idx,
    output logic              pred_taken,
    input  logic              upd_en,
    input  logic [HIST_W-1:0] upd_idx,
    input  logic              upd_taken
);
    import bp_pkg::*;

    ctr_t ctr_q [DEPTH];
    ctr_t upd_old;
    ctr_t upd_new;

    // Guess is the upper counter bit.
    assign pred_taken = ctr_q[pred_idx][1];

    // Current and next value of the counter being trained.
    always_comb begin
        upd_old = ctr_q[upd_idx];
        upd_new = ctr_step(upd_old, upd_taken);
    end

    // Counter storage: weakly taken after reset, one step per resolve.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WEAK_T;
        end else if (upd_en) begin
            ctr_q[upd_idx] <= upd_new;
        end
    end

endmodule

// File: rtl/bp_local_top.sv
// Two-level local direction predictor. The address port carries the entry
// index in its low IDX_W bits and the partial tag above them. A lookup
// result is registered and appears one cycle later. Resolves train the
// shared counter and the branch's history on the same edge. Assumes
// HIST_ENTRIES is a power of two and 2 <= HIST_W <= IDX_W + TAG_W.
module bp_local_top #(
    parameter int HIST_ENTRIES = 1024,
    parameter int TAG_W        = 8,
    parameter int HIST_W       = 6
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   lk_valid,
    input  logic [$clog2(HIST_ENTRIES)+TAG_W-1:0]  lk_pc,
    input  logic                                   upd_valid,
    input  logic [$clog2(HIST_ENTRIES)+TAG_W-1:0]  upd_pc,
    input  logic                                   upd_taken,
    output logic                                   pr_valid,
    output logic                                   pr_hit,
    output logic                                   pr_taken
);

    localparam int IDX_W = $clog2(HIST_ENTRIES);
    localparam int NRD   = 2;
    localparam int P_LK  = 0;
    localparam int P_UPD = 1;

    logic [NRD-1:0][IDX_W-1:0]  rd_idx;
    logic [NRD-1:0][TAG_W-1:0]  rd_tag;
    logic [NRD-1:0]             rd_hit;
    logic [NRD-1:0][HIST_W-1:0] rd_hist;

    logic              upd_hit;
    logic [HIST_W-1:0] upd_hist_rd;
    logic [HIST_W-1:0] upd_hist_base;
    logic [HIST_W-1:0] upd_hist_new;
    logic [HIST_W-1:0] upd_ctr_idx;
    logic [HIST_W-1:0] lk_ctr_idx;
    logic              lk_guess;

    // Split both addresses into entry index and partial tag.
    always_comb begin
        rd_idx[P_LK]  = lk_pc[IDX_W-1:0];
        rd_tag[P_LK]  = lk_pc[IDX_W +: TAG_W];
        rd_idx[P_UPD] = upd_pc[IDX_W-1:0];
        rd_tag[P_UPD] = upd_pc[IDX_W +: TAG_W];
    end

    bp_hist_cache #(
        .ENTRIES (HIST_ENTRIES),
        .TAG_W   (TAG_W),
        .HIST_W  (HIST_W),
        .NRD     (NRD)
    ) u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_tag  (rd_tag),
        .rd_hit  (rd_hit),
        .rd_hist (rd_hist),
        .wr_en   (upd_valid),
        .wr_idx  (rd_idx[P_UPD]),
        .wr_tag  (rd_tag[P_UPD]),
        .wr_hist (upd_hist_new)
    );

    // Resolve-side read results.
    always_comb begin
        upd_hit     = rd_hit[P_UPD];
        upd_hist_rd = rd_hist[P_UPD];
    end

    bp_hist_shift #(
        .HIST_W (HIST_W)
    ) u_shift (
        .hit       (upd_hit),
        .hist_rd   (upd_hist_rd),
        .taken     (upd_taken),
        .hist_base (upd_hist_base),
        .hist_new  (upd_hist_new)
    );

    // Counter indices: history folded with the low address bits.
    always_comb begin
        lk_ctr_idx  = rd_hist[P_LK] ^ lk_pc[HIST_W-1:0];
        upd_ctr_idx = upd_hist_base ^ upd_pc[HIST_W-1:0];
    end

    bp_ctr_table #(
        .HIST_W (HIST_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_idx   (lk_ctr_idx),
        .pred_taken (lk_guess),
        .upd_en     (upd_valid),
        .upd_idx    (upd_ctr_idx),
        .upd_taken  (upd_taken)
    );

    // Output register: lookup result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_valid <= 1'b0;
            pr_hit   <= 1'b0;
            pr_taken <= 1'b0;
        end else begin
            pr_valid <= lk_valid;
            pr_hit   <= lk_valid && rd_hit[P_LK];
            pr_taken <= lk_valid && rd_hit[P_LK] && lk_guess;
        end
    end

endmodule

// File: rtl/bp_local_chk.sv
// Checkers for the local predictor, attached by bind to the top module and
// to the counter table.
module bp_local_chk #(
    parameter int HIST_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              pr_valid,
    input logic              pr_hit,
    input logic              pr_taken,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic              upd_hit,
    input logic [HIST_W-1:0] upd_hist_rd,
    input logic [HIST_W-1:0] upd_hist_new
);

    AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pr_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pr_valid |-> (!pr_hit && !pr_taken)); // R2

    AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_valid && !pr_hit) |-> !pr_taken); // R3

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_hit) |->
            (upd_hist_new[HIST_W-1:1] == upd_hist_rd[HIST_W-2:0]) &&
            (upd_hist_new[0] == upd_taken)); // R6

    AST_ALLOC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_hit) |-> (upd_hist_new == HIST_W'(upd_taken))); // R7

endmodule

module bp_ctr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       upd_en,
    input logic       upd_taken,
    input logic [1:0] upd_old,
    input logic [1:0] upd_new
);

    AST_CTR_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && upd_old == 2'b11) |-> (upd_new == 2'b11)); // R5

    AST_CTR_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && upd_old == 2'b00) |-> (upd_new == 2'b00)); // R5

    AST_CTR_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && upd_old != 2'b11) |-> (upd_new == upd_old + 2'd1)); // R5

    AST_CTR_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && upd_old != 2'b00) |-> (upd_new == upd_old - 2'd1)); // R5

endmodule

bind bp_local_top bp_local_chk #(.HIST_W(HIST_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .pr_valid     (pr_valid),
    .pr_hit       (pr_hit),
    .pr_taken     (pr_taken),
    .upd_valid    (upd_valid),
    .upd_taken    (upd_taken),
    .upd_hit      (upd_hit),
    .upd_hist_rd  (upd_hist_rd),
    .upd_hist_new (upd_hist_new)
);

bind bp_ctr_table bp_ctr_chk u_ctr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .upd_taken (upd_taken),
    .upd_old   (upd_old),
    .upd_new   (upd_new)
);

// File: tb/tb_bp_local_top.sv
`timescale 1ns/1ps
// Bench for the local predictor: directed corner cases, then seeded random
// traffic, each lookup compared with a model built from the requirements.
module tb_bp_local_top;

    localparam int ENT    = 1024;
    localparam int TAG_W  = 8;
    localparam int HIST_W = 6;
    localparam int IDX_W  = 10;
    localparam int PC_W   = IDX_W + TAG_W;
    localparam int NCTR   = 1 << HIST_W;
    localparam int POOL   = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lk_valid = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic            pr_valid, pr_hit, pr_taken;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit              m_valid [ENT];
    logic [TAG_W-1:0]  m_tag [ENT];
    logic [HIST_W-1:0] m_hist[ENT];
    logic [1:0]        m_ctr [NCTR];

    bit    exp_valid = 1'b0, exp_hit = 1'b0, exp_taken = 1'b0;
    string exp_req = "R1";

    logic [PC_W-1:0] pool [POOL];
    int              bias [POOL];

    always #4 clk = ~clk;

    bp_local_top #(.HIST_ENTRIES(ENT), .TAG_W(TAG_W), .HIST_W(HIST_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_taken(pr_taken)
    );

    function automatic logic [PC_W-1:0] mk_pc(input int tag, input int idx);
        return {TAG_W'(tag), IDX_W'(idx)};
    endfunction

    // Model of R3/R4/R8: tag match, then counter bit 1 at history ^ pc bits.
    function automatic logic [1:0] m_lookup(input logic [PC_W-1:0] pc);
        int idx;
        logic [HIST_W-1:0] ci;
        idx = int'(pc[IDX_W-1:0]);
        if (!m_valid[idx] || m_tag[idx] != pc[PC_W-1:IDX_W]) return 2'b00;
        ci = m_hist[idx] ^ pc[HIST_W-1:0];
        return {1'b1, m_ctr[ci][1]};
    endfunction

    // Model of R5/R6/R7.
    task automatic m_resolve(input logic [PC_W-1:0] pc, input bit t);
        int idx;
        logic [HIST_W-1:0] h;
        logic [HIST_W-1:0] ci;
        idx = int'(pc[IDX_W-1:0]);
        h = (m_valid[idx] && m_tag[idx] == pc[PC_W-1:IDX_W]) ? m_hist[idx] : '0;
        ci = h ^ pc[HIST_W-1:0];
        if (t && m_ctr[ci] != 2'b11) m_ctr[ci] = m_ctr[ci] + 2'd1;
        if (!t && m_ctr[ci] != 2'b00) m_ctr[ci] = m_ctr[ci] - 2'd1;
        m_valid[idx] = 1'b1;
        m_tag[idx]   = pc[PC_W-1:IDX_W];
        m_hist[idx]  = {h[HIST_W-2:0], t};
    endtask

    task automatic check_out();
        checks++;
        if (pr_valid !== exp_valid || pr_hit !== exp_hit || pr_taken !== exp_taken) begin
            fails++;
            $display("FAIL %s: valid/hit/taken actual %b%b%b expected %b%b%b",
                     exp_req, pr_valid, pr_hit, pr_taken, exp_valid, exp_hit, exp_taken);
        end
    endtask

    // One cycle: check the previous lookup, drive new inputs, advance model.
    task automatic step(input bit lv, input logic [PC_W-1:0] la,
                        input bit uv, input logic [PC_W-1:0] ua,
                        input bit ut, input string req);
        logic [1:0] r;
        @(negedge clk);
        check_out();
        lk_valid = lv; lk_pc = la;
        upd_valid = uv; upd_pc = ua; upd_taken = ut;
        r = lv ? m_lookup(la) : 2'b00;
        exp_valid = lv; exp_hit = r[1]; exp_taken = r[0]; exp_req = req;
        if (uv) m_resolve(ua, ut);
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input string req);
        step(1'b1, pc, 1'b0, '0, 1'b0, req);
    endtask

    task automatic resolve(input logic [PC_W-1:0] pc, input bit t, input string req);
        step(1'b0, '0, 1'b1, pc, t, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < ENT; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; m_hist[i] = '0; end
        for (int i = 0; i < NCTR; i++) m_ctr[i] = 2'b10;
        for (int i = 0; i < POOL; i++) begin
            pool[i] = mk_pc((i / 4) * 17 + 1, (i % 4) * 300 + 3);
            bias[i] = (i * 23 + 10) % 100;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: outputs after reset (first step checks them), then empty cache.
        look(mk_pc(2, 5), "R1");
        look(mk_pc(0, 0), "R1");
        // R3: empty entry gives no hit and not-taken.
        look(mk_pc(7, 64), "R3");
        step(1'b0, '0, 1'b0, '0, 1'b0, "R2");
        // R10: two branches folded onto counter 0.
        resolve(mk_pc(1, 64), 1'b0, "R10");
        resolve(mk_pc(1, 65), 1'b1, "R10");
        look(mk_pc(1, 64), "R10");
        look(mk_pc(1, 65), "R10");
        step(1'b0, '0, 1'b0, '0, 1'b0, "R2");
        // R7: allocation on miss, then hit with history of one outcome.
        resolve(mk_pc(5, 256), 1'b1, "R7");
        look(mk_pc(5, 256), "R7");
        // R6: history shifting visible through the guesses.
        resolve(mk_pc(5, 256), 1'b0, "R6");
        look(mk_pc(5, 256), "R6");
        resolve(mk_pc(5, 256), 1'b1, "R6");
        look(mk_pc(5, 256), "R6");
        // R5: drive one branch well beyond both ends of the counter.
        for (int k = 0; k < 10; k++) begin
            resolve(mk_pc(9, 128), 1'b1, "R5");
            look(mk_pc(9, 128), "R5");
        end
        for (int k = 0; k < 12; k++) begin
            resolve(mk_pc(9, 128), 1'b0, "R5");
            look(mk_pc(9, 128), "R5");
        end
        // R9: same-edge lookup and resolve of one branch.
        step(1'b1, mk_pc(9, 128), 1'b1, mk_pc(9, 128), 1'b1, "R9");
        step(1'b1, mk_pc(9, 128), 1'b1, mk_pc(9, 128), 1'b1, "R9");
        look(mk_pc(9, 128), "R9");
        // R8: same index, different tags evict each other.
        resolve(mk_pc(3, 7), 1'b1, "R8");
        look(mk_pc(4, 7), "R8");
        resolve(mk_pc(4, 7), 1'b1, "R8");
        look(mk_pc(3, 7), "R8");
        look(mk_pc(4, 7), "R8");
        // R4: random mix over a pool of conflicting branches.
        for (int n = 0; n < 4000; n++) begin
            int a, b;
            bit lv, uv, ut;
            a  = $urandom_range(POOL - 1);
            b  = ($urandom_range(3) == 0) ? a : $urandom_range(POOL - 1);
            lv = ($urandom_range(3) != 0);
            uv = ($urandom_range(1) == 1);
            ut = ($urandom_range(99) < bias[b]);
            step(lv, pool[a], uv, pool[b], ut, "R4");
        end
        step(1'b0, '0, 1'b0, '0, 1'b0, "R2");
        step(1'b0, '0, 1'b0, '0, 1'b0, "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule